// File: doc/BRIEF.md
# Byte-Wide Memory to Serial Configuration Streamer

This block reads a configuration image from an external byte-wide memory and turns it into a serial bitstream. After a start pulse it drives an address bus that begins at zero and steps by one for each byte. It generates a read clock for the memory and captures the returned byte on each rising read-clock edge. It then shifts each byte out least significant bit first on a serial data line. A serial clock runs at eight times the read-clock rate, so devices further down a daisy chain can load the same stream. New serial data is launched at the falling serial-clock edge, which lets a receiver sample it on the rising edge.

Both output clocks are registered signals derived from the single system clock, so the logic stays in one clock domain. The serial clock period is `2*SCK_HALF_CYC` system cycles. The first read-clock period is a prefetch period: the first byte is captured during it and the serial clock stays idle. Each later read-clock period carries the previous byte out while the next byte is fetched. Once `BYTE_TOTAL` bytes have been shifted out, both clocks stop low and a done flag rises. A parameter can mirror the data lines, for memories that are wired in reversed order.

Top module: `cfg_stream_loader`

## Requirements
- R1: After synchronous reset (rst_n low) mem_addr is 0 and rd_clk, ser_clk, ser_dout and load_done are 0. They stay there, with no clock edges, until start is pulsed.
- R2: The first rd_clk rising edge after a start has mem_addr = 0. Each later rd_clk rise has the previous address plus one. mem_addr stays stable while rd_clk is high.
- R3: With MIRROR_DATA = 0, the bit present on ser_dout at the k-th rising ser_clk edge after a start (k from 0) is bit (k mod 8) of the byte captured at rd_clk rise number k/8. Bit 0 is sent first.
- R4: With MIRROR_DATA = 1, that bit is bit 7 − (k mod 8) of the captured byte.
- R5: ser_dout changes only while ser_clk is low and is stable during every ser_clk high phase. This includes the sample where ser_clk rises.
- R6: The serial clock stays idle during the first rd_clk period. After that there are exactly eight ser_clk rising edges between consecutive rd_clk rising edges. The ser_clk period is 2*SCK_HALF_CYC system cycles.
- R7: A full load gives exactly BYTE_TOTAL rd_clk rises and 8*BYTE_TOTAL ser_clk rises. load_done then rises 16*SCK_HALF_CYC*(BYTE_TOTAL+1) cycles after the clock edge that takes start. When load_done rises, mem_addr equals BYTE_TOTAL.
- R8: After load_done rises, rd_clk and ser_clk are held low and load_done stays high until the next start or reset.
- R9: A start pulse during a load or after done restarts from address 0. load_done is cleared on the next cycle, and the new stream begins again with bit 0 of byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a load |
| mem_addr | output | ADDR_W | Byte address to the memory |
| mem_data | input | 8 | Byte returned by the memory |
| rd_clk | output | 1 | Memory read clock; data captured on its rising edge |
| ser_clk | output | 1 | Serial clock, eight times the read-clock rate |
| ser_dout | output | 1 | Serial data, launched on the falling ser_clk edge |
| load_done | output | 1 | High once the whole image has been shifted out |

## Verification
The bench goes after the byte boundary. A design that loads the next byte one half-period late, or shifts once too often, would repeat or skip a bit across bytes 0 and 1. The bench also probes the prefetch period: a design that let the serial clock run during it would clock out eight stale bits and break the eight-edges-per-read-period count. Restarts are driven both mid-byte and after done. A sequencer that failed to clear its window or shifter state would resume at a non-zero address or emit a leftover bit first. The mirrored instance catches a reversal applied in the wrong place, because the same memory image must come out bit-reversed within every byte.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_DONE = 2'd2
    } ld_state_e;

    localparam int unsigned HALVES_PER_BYTE = 16;

endpackage

// File: rtl/cfgld_tick.sv
module cfgld_tick #(
    parameter int unsigned SCK_HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (SCK_HALF_CYC > 1) ? $clog2(SCK_HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
    parameter bit MIRROR_DATA = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] byte_in,
    output logic       dout
);
    typedef struct packed {
        logic [7:0] sh;
        logic       dout;
    } shf_t;

    shf_t       r_d, r_q;
    logic [7:0] lane;

    generate
        if (MIRROR_DATA) begin : g_mirror
            always_comb begin
                for (int i = 0; i < 8; i++) lane[i] = byte_in[7-i];
            end
        end else begin : g_straight
            assign lane = byte_in;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else if (load) begin
            r_d.sh   = lane;
            r_d.dout = lane[0];
        end else if (shift) begin
            r_d.sh   = {1'b0, r_q.sh[7:1]};
            r_d.dout = r_q.sh[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.dout;
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W       = 18,
    parameter int unsigned BYTE_TOTAL   = 16,
    parameter int unsigned SCK_HALF_CYC = 2,
    parameter bit          MIRROR_DATA  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic              rd_clk,
    output logic              ser_clk,
    output logic              ser_dout,
    output logic              load_done
);
    localparam int unsigned WW = $clog2(BYTE_TOTAL + 2);
    localparam logic [WW-1:0] LAST_WIN = WW'(BYTE_TOTAL);
    localparam logic [3:0] HP_LAST = 4'(HALVES_PER_BYTE - 1);
    localparam logic [3:0] HP_CAPTURE = 4'(HALVES_PER_BYTE / 2);

    typedef struct packed {
        ld_state_e         st;
        logic [WW-1:0]     win;
        logic [3:0]        hp;
        logic              sck;
        logic              rclk;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        hold;
        logic              done;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tick, tk_clr;
    logic          sh_clr, sh_load, sh_shift;
    logic [3:0]    hp_n;
    logic          wrap;
    logic [WW-1:0] win_n;

    cfgld_tick #(.SCK_HALF_CYC(SCK_HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tk_clr),
        .run   (s_q.st == LD_RUN),
        .tick  (tick)
    );

    cfgld_shifter #(.MIRROR_DATA(MIRROR_DATA)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sh_clr),
        .load    (sh_load),
        .shift   (sh_shift),
        .byte_in (s_q.hold),
        .dout    (ser_dout)
    );

    always_comb begin
        s_d      = s_q;
        tk_clr   = 1'b0;
        sh_clr   = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        hp_n     = s_q.hp + 4'd1;
        wrap     = (s_q.hp == HP_LAST);
        win_n    = s_q.win + (wrap ? WW'(1) : WW'(0));

        if (start) begin
            s_d    = '0;
            s_d.st = LD_RUN;
            tk_clr = 1'b1;
            sh_clr = 1'b1;
        end else if (s_q.st == LD_RUN && tick) begin
            s_d.hp = hp_n;
            if (wrap && s_q.win == LAST_WIN) begin
                s_d.st   = LD_DONE;
                s_d.sck  = 1'b0;
                s_d.rclk = 1'b0;
                s_d.done = 1'b1;
                sh_clr   = 1'b1;
            end else begin
                s_d.win  = win_n;
                s_d.sck  = (win_n != '0) && hp_n[0];
                s_d.rclk = (win_n < LAST_WIN) && hp_n[3];
                if ((win_n < LAST_WIN) && (hp_n == HP_CAPTURE)) begin
                    s_d.hold = mem_data;
                end
                if (wrap) begin
                    s_d.addr = s_q.addr + ADDR_W'(1);
                    sh_load  = 1'b1;
                end else if (!hp_n[0] && (s_q.win != '0)) begin
                    sh_shift = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_addr  = s_q.addr;
    assign rd_clk    = s_q.rclk;
    assign ser_clk   = s_q.sck;
    assign load_done = s_q.done;
endmodule

// File: rtl/cfgld_checks.sv
module cfgld_checks #(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned BYTE_TOTAL = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_clk,
    input logic              ser_clk,
    input logic              ser_dout,
    input logic              load_done
);
    // R5: data holds through the whole high phase of the serial clock
    p_dout_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_dout));

    // R2: address frozen while the read clock is high
    p_addr_hold_rclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clk |-> $stable(mem_addr));

    // R2: address only steps by one or returns to zero
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |->
            ((mem_addr == $past(mem_addr) + ADDR_W'(1)) || (mem_addr == '0)));

    // R8: both clocks parked low once done
    p_clocks_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!ser_clk && !rd_clk));

    // R8: done persists until a start
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_done) && !$past(start)) |-> load_done);

    // R9: start clears done on the next cycle
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!load_done && mem_addr == '0));

    // R7: address never exceeds the image length
    p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr <= ADDR_W'(BYTE_TOTAL));
endmodule

bind cfg_stream_loader cfgld_checks #(
    .ADDR_W     (ADDR_W),
    .BYTE_TOTAL (BYTE_TOTAL)
) u_cfgld_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .rd_clk    (rd_clk),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout),
    .load_done (load_done)
);

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb_top;
    localparam int AW = 18;
    localparam int NB = 5;
    localparam int H  = 2;
    localparam int DONE_CYC = 16 * H * (NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    int   seed = 0;

    logic [AW-1:0] addr_w [2];
    logic [7:0]    data_w [2];
    logic          rclk_w [2];
    logic          sck_w  [2];
    logic          sdo_w  [2];
    logic          done_w [2];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(int a, int s);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1 + 32'(s);
        return x[23:16] ^ x[7:0] ^ x[31:24];
    endfunction

    assign data_w[0] = mem_byte(int'(addr_w[0]), seed);
    assign data_w[1] = mem_byte(int'(addr_w[1]), seed);

    cfg_stream_loader #(.ADDR_W(AW), .BYTE_TOTAL(NB), .SCK_HALF_CYC(H), .MIRROR_DATA(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_w[0]), .mem_data(data_w[0]),
        .rd_clk(rclk_w[0]), .ser_clk(sck_w[0]), .ser_dout(sdo_w[0]), .load_done(done_w[0]));

    cfg_stream_loader #(.ADDR_W(AW), .BYTE_TOTAL(NB), .SCK_HALF_CYC(H), .MIRROR_DATA(1'b1)) dut_m (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_w[1]), .mem_data(data_w[1]),
        .rd_clk(rclk_w[1]), .ser_clk(sck_w[1]), .ser_dout(sdo_w[1]), .load_done(done_w[1]));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // monitor state
    bit active = 1'b0;
    int cyc = 0;
    int bitn[2], rn[2], since_r[2], stray[2];
    logic psck[2], prclk[2], pdone[2], psdo[2];

    initial begin
        for (int i = 0; i < 2; i++) begin
            bitn[i] = 0; rn[i] = 0; since_r[i] = 0; stray[i] = 0;
            psck[i] = 1'b0; prclk[i] = 1'b0; pdone[i] = 1'b0; psdo[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            active = 1'b0;
        end else if (start) begin
            active = 1'b1;
            cyc = -1;
            for (int i = 0; i < 2; i++) begin
                bitn[i] = 0; rn[i] = 0; since_r[i] = 0;
            end
        end else if (active) begin
            cyc++;
        end
        for (int i = 0; i < 2; i++) begin
            string rq;
            rq = (i == 0) ? "R3" : "R4";
            if (rst_n && !active && (sck_w[i] || rclk_w[i])) stray[i]++;
            if (rst_n && active && !start) begin
                if (sck_w[i] && !psck[i]) begin
                    int bi; logic [7:0] b; logic e;
                    chk(sdo_w[i] == psdo[i], "R5", "sdo changed at ser_clk rise", int'(sdo_w[i]), int'(psdo[i]));
                    if (bitn[i] < 8 * NB) begin
                        bi = bitn[i] % 8;
                        b  = mem_byte(bitn[i] / 8, seed);
                        e  = (i == 0) ? b[bi] : b[7 - bi];
                        chk(sdo_w[i] == e, rq, "serial bit", int'(sdo_w[i]), int'(e));
                    end else begin
                        chk(1'b0, "R7", "extra ser_clk rise", bitn[i], 8 * NB);
                    end
                    bitn[i]++;
                    since_r[i]++;
                end
                if (rclk_w[i] && !prclk[i]) begin
                    chk(int'(addr_w[i]) == rn[i], "R2", "address at rd_clk rise", int'(addr_w[i]), rn[i]);
                    if (rn[i] == 1) chk(since_r[i] == 4, "R6", "ser_clk rises in prefetch+half", since_r[i], 4);
                    if (rn[i] >= 2) chk(since_r[i] == 8, "R6", "ser_clk rises per rd_clk period", since_r[i], 8);
                    rn[i]++;
                    since_r[i] = 0;
                end
                if (done_w[i] && !pdone[i]) begin
                    chk(bitn[i] == 8 * NB, "R7", "ser_clk rises at done", bitn[i], 8 * NB);
                    chk(rn[i] == NB, "R7", "rd_clk rises at done", rn[i], NB);
                    chk(int'(addr_w[i]) == NB, "R7", "address at done", int'(addr_w[i]), NB);
                    chk(cyc == DONE_CYC, "R7", "cycles to done", cyc, DONE_CYC);
                end
            end
            psck[i] = sck_w[i]; prclk[i] = rclk_w[i]; pdone[i] = done_w[i]; psdo[i] = sdo_w[i];
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic check_idle_outputs(input string req);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(addr_w[i] == '0, req, "address idle", int'(addr_w[i]), 0);
            chk({rclk_w[i], sck_w[i], sdo_w[i], done_w[i]} == 4'b0, req, "outputs idle",
                int'({rclk_w[i], sck_w[i], sdo_w[i], done_w[i]}), 0);
        end
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!(done_w[0] && done_w[1]) && n < 4 * DONE_CYC) begin
            @(negedge clk);
            n++;
        end
        chk(done_w[0] && done_w[1], "R7", "done reached", int'({done_w[1], done_w[0]}), 3);
    endtask

    task automatic check_parked(input int wait_cyc);
        repeat (wait_cyc) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(done_w[i] == 1'b1, "R8", "done held", int'(done_w[i]), 1);
            chk(!sck_w[i] && !rclk_w[i], "R8", "clocks parked", int'({sck_w[i], rclk_w[i]}), 0);
            chk(int'(addr_w[i]) == NB, "R8", "address held", int'(addr_w[i]), NB);
        end
    endtask

    task automatic check_restart_cleared();
        // start just taken: next sample shows cleared state
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(!done_w[i], "R9", "done cleared by start", int'(done_w[i]), 0);
            chk(addr_w[i] == '0, "R9", "address back to zero", int'(addr_w[i]), 0);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_C0DE);
        seed = 32'h1234;
        // R1: reset state and idleness without start
        do_reset();
        check_idle_outputs("R1");
        repeat (40) @(negedge clk);
        check_idle_outputs("R1");
        chk(stray[0] == 0 && stray[1] == 0, "R1", "clock edges before start", stray[0] + stray[1], 0);

        // directed full load
        pulse_start();
        wait_done();
        check_parked(25);

        // R9: start after done
        seed = 32'h00FF_00FF;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        check_restart_cleared();
        wait_done();
        check_parked(3);

        // directed: restart right at the first byte boundary region
        seed = 32'h0BAD_F00D;
        pulse_start();
        repeat (16 * H + 3) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        check_restart_cleared();
        wait_done();

        // constrained random runs
        for (int r = 0; r < 10; r++) begin
            int mode;
            mode = int'($urandom % 3);
            seed = int'($urandom);
            pulse_start();
            if (mode == 1) begin
                repeat (5 + int'($urandom % (DONE_CYC - 10))) @(posedge clk);
                #1 start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
                check_restart_cleared();
                wait_done();
                check_parked(1 + int'($urandom % 8));
            end else if (mode == 2) begin
                repeat (5 + int'($urandom % (DONE_CYC - 10))) @(posedge clk);
                do_reset();
                check_idle_outputs("R1");
                repeat (10) @(negedge clk);
                check_idle_outputs("R1");
                pulse_start();
                wait_done();
            end else begin
                wait_done();
                check_parked(1 + int'($urandom % 8));
            end
        end

        chk(stray[0] == 0 && stray[1] == 0, "R1", "stray clock edges while idle", stray[0] + stray[1], 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule